// File: doc/BRIEF.md
# DRAM-to-SRAM Strobe Bridge

This block lets a controller built for a multiplexed-address dynamic RAM drive a static RAM. The controller presents a 9-bit address twice: first the row half, marked by the falling row strobe, then the column half, marked by the falling edge of either column strobe. The bridge keeps both halves and joins them into an 18-bit word address. It then drives chip enable, read enable, write enable and two byte enables on the static RAM side.

The static RAM needs no refresh, so the bridge passes on only genuine access cycles. An access is a cycle in which the row strobe falls while both column strobes are high, and a column strobe then falls before the row strobe rises again. RAS-only refresh and CAS-before-RAS refresh never reach the static RAM. Every DRAM-side input is sampled on a fast system clock through a synchroniser. The outputs therefore follow the pins with a fixed latency of a few clocks, which stays inside the column access window.

Top module: `dram_sram_bridge`

## Requirements
- R1: While reset is active and after it is released with idle inputs (all strobes high), sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n and sram_lb_n are 1 and sram_addr is 0.
- R2: The address present when the row strobe falls appears as sram_addr[17:9] and is held until the next row strobe fall.
- R3: The address present when a column strobe falls, within a row-first cycle, appears as sram_addr[8:0].
- R4: sram_ce_n goes low only when the row strobe fell with both column strobes high and one column strobe then fell while the row strobe stayed low.
- R5: A cycle in which a column strobe is already low when the row strobe falls (CAS-before-RAS refresh) never drives sram_ce_n, sram_oe_n or sram_we_n low.
- R6: A row strobe low period in which no column strobe falls (RAS-only refresh) never drives any static RAM strobe low.
- R7: During an access, sram_ub_n is low exactly when the upper column strobe is low, and sram_lb_n is low exactly when the lower column strobe is low. Both are 1 outside an access.
- R8: If dram_we_n is 0 when the column strobe falls, the access is a write (sram_we_n = 0, sram_oe_n = 1). Otherwise it is a read (sram_oe_n = 0, sram_we_n = 1).
- R9: When the row strobe rises, every static RAM strobe returns to 1 one clock after the synchronised rise, and a new access requires a new row strobe fall.
- R10: With SYNC_STAGES = 2, an output responds on the third rising clock edge after the input change: two synchroniser stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dram_ras_n | input | 1 | Row strobe, active low |
| dram_casu_n | input | 1 | Upper byte column strobe, active low |
| dram_casl_n | input | 1 | Lower byte column strobe, active low |
| dram_we_n | input | 1 | Write request, active low |
| dram_addr | input | 9 | Multiplexed row/column address |
| sram_addr | output | 18 | Word address {row, column} |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Read enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |

## Verification
The hardest case is strobe ordering that differs by a single sample. One example is a column strobe that falls on the same synchronised sample as the row strobe. Another is a column strobe that stays low across the row strobe fall, which must count as refresh. A third is a second row period that begins without a fresh row-first condition. The stimulus drives these orderings at the pins, with single-clock spacing. A cycle-accurate model in the bench judges each one and compares every output on every clock. It also counts, per scenario, any clock with chip enable low during a refresh.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int ROW_W = 9;
  localparam int COL_W = 9;
  localparam int ADDR_W = ROW_W + COL_W;

  typedef struct packed {
    logic             ras_n;
    logic             casu_n;
    logic             casl_n;
    logic             we_n;
    logic [COL_W-1:0] addr;
  } dram_bus_t;

  localparam int BUS_W = $bits(dram_bus_t);
  localparam dram_bus_t BUS_IDLE = '{ras_n: 1'b1, casu_n: 1'b1, casl_n: 1'b1,
                                     we_n: 1'b1, addr: '0};
endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dsb_edge.sv
module dsb_edge (
  input  logic clk,
  input  logic rst_n,
  input  dsb_pkg::dram_bus_t cur,
  output logic ras_fall,
  output logic casu_fall,
  output logic casl_fall
);
  logic [2:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b111;
    else        prev_q <= {cur.ras_n, cur.casu_n, cur.casl_n};
  end

  assign ras_fall  = prev_q[2] & ~cur.ras_n;
  assign casu_fall = prev_q[1] & ~cur.casu_n;
  assign casl_fall = prev_q[0] & ~cur.casl_n;
endmodule

// File: rtl/dsb_seq.sv
module dsb_seq (
  input  logic clk,
  input  logic rst_n,
  input  dsb_pkg::dram_bus_t cur,
  input  logic ras_fall,
  input  logic casu_fall,
  input  logic casl_fall,
  output logic [dsb_pkg::ADDR_W-1:0] sram_addr,
  output logic sram_ce_n,
  output logic sram_oe_n,
  output logic sram_we_n,
  output logic sram_ub_n,
  output logic sram_lb_n
);
  import dsb_pkg::*;

  logic             first_q, first_d;
  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic             ub_q, ub_d;
  logic             lb_q, lb_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             any_cas_fall;
  logic             col_take;

  assign any_cas_fall = casu_fall | casl_fall;
  assign col_take     = ~cur.ras_n & first_q & any_cas_fall;

  always_comb begin
    first_d = first_q;
    act_d   = act_q;
    wr_d    = wr_q;
    row_d   = row_q;
    col_d   = col_q;
    if (cur.ras_n) begin
      first_d = 1'b0;
      act_d   = 1'b0;
    end else if (ras_fall) begin
      row_d   = cur.addr;
      first_d = cur.casu_n & cur.casl_n;
    end else if (col_take) begin
      col_d = cur.addr;
      wr_d  = ~cur.we_n;
      act_d = 1'b1;
    end
    ub_d = act_d & ~cur.casu_n;
    lb_d = act_d & ~cur.casl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ub_q    <= 1'b0;
      lb_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      first_q <= first_d;
      act_q   <= act_d;
      wr_q    <= wr_d;
      ub_q    <= ub_d;
      lb_q    <= lb_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  assign sram_addr = {row_q, col_q};
  assign sram_ce_n = ~act_q;
  assign sram_oe_n = ~(act_q & ~wr_q);
  assign sram_we_n = ~(act_q & wr_q);
  assign sram_ub_n = ~ub_q;
  assign sram_lb_n = ~lb_q;

  // R2: row half follows the address seen at the row strobe fall
  assert_row_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall |=> (row_q == $past(cur.addr)));
  // R3: column half taken when an access starts
  assert_col_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (col_q == $past(cur.addr)));
  // R4: an access begins only after a row-first condition
  assert_access_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(first_q));
  // R6: no access without a column strobe fall under a low row strobe
  assert_needs_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(any_cas_fall) && !$past(cur.ras_n)));
  // R7: byte lanes only inside an access
  assert_lane_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ub_q || lb_q) |-> act_q);
  // R9: row strobe high ends the access on the next clock
  assert_ras_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur.ras_n |=> (sram_ce_n && sram_ub_n && sram_lb_n && !first_q));
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dram_ras_n,
  input  logic        dram_casu_n,
  input  logic        dram_casl_n,
  input  logic        dram_we_n,
  input  logic [8:0]  dram_addr,
  output logic [17:0] sram_addr,
  output logic        sram_ce_n,
  output logic        sram_oe_n,
  output logic        sram_we_n,
  output logic        sram_ub_n,
  output logic        sram_lb_n
);
  import dsb_pkg::*;

  dram_bus_t raw_bus, cur_bus;
  logic [BUS_W-1:0] cur_vec;
  logic ras_fall, casu_fall, casl_fall;

  assign raw_bus = '{ras_n: dram_ras_n, casu_n: dram_casu_n,
                     casl_n: dram_casl_n, we_n: dram_we_n, addr: dram_addr};

  dsb_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(cur_vec));

  assign cur_bus = cur_vec;

  dsb_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cur(cur_bus),
    .ras_fall(ras_fall), .casu_fall(casu_fall), .casl_fall(casl_fall));

  dsb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cur(cur_bus),
    .ras_fall(ras_fall), .casu_fall(casu_fall), .casl_fall(casl_fall),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n));

  // R8: read and write enables never both active
  assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));
  // R5: strobes low only while chip enable is low
  assert_strobe_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n || !sram_we_n) |-> !sram_ce_n);
endmodule

// File: tb/dram_sram_bridge_bench.sv
module dram_sram_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, casu_n = 1'b1, casl_n = 1'b1, we_n = 1'b1;
  logic [8:0] addr = '0;
  logic [17:0] s_addr;
  logic s_ce_n, s_oe_n, s_we_n, s_ub_n, s_lb_n;

  int checks = 0;
  int errors = 0;
  int ce_hits = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_sram_bridge u_dram_sram_bridge (
    .clk(clk), .rst_n(rst_n), .dram_ras_n(ras_n), .dram_casu_n(casu_n),
    .dram_casl_n(casl_n), .dram_we_n(we_n), .dram_addr(addr),
    .sram_addr(s_addr), .sram_ce_n(s_ce_n), .sram_oe_n(s_oe_n),
    .sram_we_n(s_we_n), .sram_ub_n(s_ub_n), .sram_lb_n(s_lb_n));

  // reference model: history of pin samples, newest first
  logic [12:0] hist [4];
  bit m_first, m_act, m_wr, m_ub, m_lb;
  logic [8:0] m_row, m_col;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = {4'b1111, 9'h0};
      m_first = 0; m_act = 0; m_wr = 0; m_ub = 0; m_lb = 0;
      m_row = '0; m_col = '0;
    end else begin
      logic [12:0] now, old;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {ras_n, casu_n, casl_n, we_n, addr};
      now = hist[2];
      old = hist[3];
      if (now[12]) begin
        m_first = 0; m_act = 0;
      end else if (old[12]) begin
        m_row = now[8:0];
        m_first = now[11] && now[10];
      end else if (m_first && ((old[11] && !now[11]) || (old[10] && !now[10]))) begin
        m_col = now[8:0]; m_wr = !now[9]; m_act = 1;
      end
      m_ub = m_act && !now[11];
      m_lb = m_act && !now[10];
    end
    #2;
    if (rst_n) begin
      cyc++;
      if (!s_ce_n) ce_hits++;
      check("R4", "ce_n", s_ce_n, !m_act);
      check("R2", "addr_row", s_addr[17:9], m_row);
      check("R3", "addr_col", s_addr[8:0], m_col);
      check("R8", "oe_n", s_oe_n, !(m_act && !m_wr));
      check("R8", "we_n", s_we_n, !(m_act && m_wr));
      check("R7", "ub_n", s_ub_n, !m_ub);
      check("R7", "lb_n", s_lb_n, !m_lb);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [8:0] row, input logic [8:0] col,
                        input bit wr, input bit up, input bit lo);
    addr = row; step(2);
    ras_n = 0; step(2);
    addr = col; we_n = !wr; step(1);
    casu_n = !up; casl_n = !lo; step(5);
    casu_n = 1; casl_n = 1; step(1);
    ras_n = 1; we_n = 1; step(4);
  endtask

  initial begin
    step(3);
    check("R1", "reset ce_n", s_ce_n, 1);
    check("R1", "reset oe/we/ub/lb", {s_oe_n, s_we_n, s_ub_n, s_lb_n}, 4'hf);
    check("R1", "reset addr", s_addr, 0);
    rst_n = 1;
    step(4);
    check("R1", "post-reset idle", {s_ce_n, s_oe_n, s_we_n, s_ub_n, s_lb_n}, 5'h1f);

    // R10: latency of exactly three edges after the change
    addr = 9'h155; step(2); ras_n = 0; step(2); addr = 9'h0aa;
    step(1); casl_n = 0;
    @(posedge clk); #1 check("R10", "ce_n after 1 edge", s_ce_n, 1);
    @(posedge clk); #1 check("R10", "ce_n after 2 edges", s_ce_n, 1);
    @(posedge clk); #1 check("R10", "ce_n after 3 edges", s_ce_n, 0);
    check("R2", "row/col joined", s_addr, {9'h155, 9'h0aa});
    check("R8", "read oe_n", s_oe_n, 0);
    step(3); casl_n = 1; ras_n = 1; step(5);
    check("R9", "released after RAS rise", s_ce_n, 1);

    access(9'h1ff, 9'h001, 1, 1, 1);
    access(9'h000, 9'h1fe, 0, 1, 0);
    access(9'h0f0, 9'h10f, 1, 0, 1);

    // R5: CAS-before-RAS refresh
    ce_hits = 0;
    casu_n = 0; casl_n = 0; step(2); ras_n = 0; step(6);
    casu_n = 1; casl_n = 1; step(2); ras_n = 1; step(4);
    check("R5", "CBR ce clocks", ce_hits, 0);
    // R5: CAS and RAS falling on the same sample
    ce_hits = 0;
    ras_n = 0; casl_n = 0; step(6); casl_n = 1; ras_n = 1; step(4);
    check("R5", "simultaneous fall ce clocks", ce_hits, 0);
    // R6: RAS-only refresh
    ce_hits = 0;
    addr = 9'h033; ras_n = 0; step(8); ras_n = 1; step(4);
    check("R6", "RAS-only ce clocks", ce_hits, 0);
    // R9: CAS toggle after RAS rise and CAS held across new RAS fall
    ce_hits = 0;
    casu_n = 0; step(3); ras_n = 0; step(3); casu_n = 1; step(2);
    casu_n = 0; step(3); casu_n = 1; ras_n = 1; step(4);
    check("R9", "no access without fresh row-first", ce_hits, 0);

    // page-style second CAS in one access, lanes swap
    addr = 9'h0c3; step(1); ras_n = 0; step(2); addr = 9'h03c; we_n = 0;
    casu_n = 0; step(4); casu_n = 1; step(1); addr = 9'h111; we_n = 1;
    casl_n = 0; step(4);
    check("R7", "lower lane on second CAS", {s_ub_n, s_lb_n}, 2'b10);
    casl_n = 1; ras_n = 1; step(5);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule